// File: doc/BRIEF.md
# Single-Bit Shift, Rotate, Clear and Complement Unit with Condition Flags

This block is the bit-manipulation slice of an 8/16-bit datapath. In one combinational pass it takes an operation code, an operand, a width select and the current 8-bit condition register. It returns the shifted, rotated, cleared or complemented result and the updated condition register. Rotates take the incoming carry from the condition register and return the bit that falls out through the same carry position.

The unit has two lanes, an 8-bit one and a 16-bit one, built from the same parameterised core. The width select routes an operation to the 16-bit lane only for logical shifts, clear and the no-op. Every other operation always works on the low byte. A flag generator turns the lane result and the carry-out into the low nibble of the condition register. The upper nibble passes through untouched. The unit has no state. The "states" of the house style are the eight operation codes, and the only "transition" is the lane selection decided by the width select.

Condition register layout, which every requirement relies on: bit 7 stop-disable, bit 6 extended-interrupt mask, bit 5 half-carry, bit 4 interrupt mask, bit 3 N, bit 2 Z, bit 1 V, bit 0 C.

Top module: `sru_shift_unit`

## Requirements
- R1: Logical shift right (op code 0) shifts the active width right by one and puts zero into its top bit. C takes operand bit 0.
- R2: Shift left (op code 1) shifts the active width left by one and puts zero into bit 0. C takes operand bit 7 in 8-bit mode, or bit 15 in 16-bit mode.
- R3: Arithmetic shift right (op code 2) keeps result bit 7 equal to operand bit 7 and sets result[6:0] = operand[7:1]. C takes operand bit 0.
- R4: Rotate right (op code 3) sets result bit 7 to the old C (ccr_in bit 0) and result[6:0] to operand[7:1]. C takes operand bit 0.
- R5: Rotate left (op code 4) sets result bit 0 to the old C and result[7:1] to operand[6:0]. C takes operand bit 7.
- R6: For op codes 0 to 4, N (bit 3) is the top bit of the active-width result, Z (bit 2) is set exactly when that result is zero, and V (bit 1) is N xor the new C.
- R7: Complement (op code 5) returns ~operand[7:0] and updates N and Z from it. It sets C to 1 and clears V.
- R8: Clear (op code 6) returns zero, sets Z and clears N, V and C.
- R9: Every operation leaves ccr_out bits 7 to 4 equal to ccr_in bits 7 to 4.
- R10: No-op (op code 7) returns the operand masked to the active width and leaves the whole condition register unchanged.
- R11: The width select (1 = 16-bit) is honoured only for op codes 0, 1, 6 and 7. In 8-bit operation, result bits 15 to 8 are zero and operand bits 15 to 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 3 | Operation code (0 LSR, 1 LSL, 2 ASR, 3 ROR, 4 ROL, 5 COM, 6 CLR, 7 NOP) |
| wide | input | 1 | Width select, 1 = 16-bit for the ops that allow it |
| operand | input | 16 | Source operand |
| ccr_in | input | 8 | Current condition register |
| result | output | 16 | Operation result, zero-extended in 8-bit mode |
| ccr_out | output | 8 | Updated condition register |

## Verification
Every evaluation is covered by assertions for several rules: the upper condition nibble is preserved, V equals N xor C for shifts and rotates, complement forces C high and V low, clear produces a zero result with the fixed flag nibble, the no-op leaves the register alone, and narrow results have a zero upper byte. Other behaviour is shown only by the bench's scenarios against its reference model. This covers the exact bit movements, carry-in through the rotates, bit 15 versus bit 7 feeding C on a wide left shift, and the width select being ignored by arithmetic shift, rotate and complement. Those scenarios include directed corner values (all zeros, all ones, single set top or bottom bits, results that just become zero) and a pseudo-random sweep.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int CCR_W   = 8;
    localparam int FLAG_N  = 3;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_V  = 1;
    localparam int FLAG_C  = 0;
    localparam int NIB_W   = 4;

    typedef enum logic [2:0] {
        OP_LSR = 3'd0,
        OP_LSL = 3'd1,
        OP_ASR = 3'd2,
        OP_ROR = 3'd3,
        OP_ROL = 3'd4,
        OP_COM = 3'd5,
        OP_CLR = 3'd6,
        OP_NOP = 3'd7
    } sru_op_e;

    function automatic logic op_allows_wide(sru_op_e o);
        return (o == OP_LSR) || (o == OP_LSL) || (o == OP_CLR) || (o == OP_NOP);
    endfunction

    function automatic logic op_is_shift(sru_op_e o);
        return (o == OP_LSR) || (o == OP_LSL) || (o == OP_ASR) ||
               (o == OP_ROR) || (o == OP_ROL);
    endfunction

endpackage

// File: rtl/sru_shift_core.sv
module sru_shift_core
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e        op,
    input  logic [W-1:0]   src,
    input  logic           cin,
    output logic [W-1:0]   res,
    output logic           cout
);

    always_comb begin
        unique case (op)
            OP_LSR: begin
                res  = {1'b0, src[W-1:1]};
                cout = src[0];
            end
            OP_LSL: begin
                res  = {src[W-2:0], 1'b0};
                cout = src[W-1];
            end
            OP_ASR: begin
                res  = {src[W-1], src[W-1:1]};
                cout = src[0];
            end
            OP_ROR: begin
                res  = {cin, src[W-1:1]};
                cout = src[0];
            end
            OP_ROL: begin
                res  = {src[W-2:0], cin};
                cout = src[W-1];
            end
            OP_COM: begin
                res  = ~src;
                cout = 1'b1;
            end
            OP_CLR: begin
                res  = '0;
                cout = 1'b0;
            end
            OP_NOP: begin
                res  = src;
                cout = cin;
            end
            default: begin
                res  = src;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/sru_flag_gen.sv
module sru_flag_gen
    import sru_pkg::*;
#(
    parameter int W = 8
) (
    input  sru_op_e             op,
    input  logic [W-1:0]        res,
    input  logic                cout,
    input  logic [NIB_W-1:0]    nib_in,
    output logic [NIB_W-1:0]    nib_out
);

    logic msb;
    logic is_zero;

    assign msb     = res[W-1];
    assign is_zero = (res == '0);

    always_comb begin
        nib_out = nib_in;
        unique case (op)
            OP_LSR, OP_LSL, OP_ASR, OP_ROR, OP_ROL: begin
                nib_out[FLAG_N] = msb;
                nib_out[FLAG_Z] = is_zero;
                nib_out[FLAG_V] = msb ^ cout;
                nib_out[FLAG_C] = cout;
            end
            OP_COM: begin
                nib_out[FLAG_N] = msb;
                nib_out[FLAG_Z] = is_zero;
                nib_out[FLAG_V] = 1'b0;
                nib_out[FLAG_C] = 1'b1;
            end
            OP_CLR: begin
                nib_out[FLAG_N] = 1'b0;
                nib_out[FLAG_Z] = 1'b1;
                nib_out[FLAG_V] = 1'b0;
                nib_out[FLAG_C] = 1'b0;
            end
            OP_NOP: begin
                nib_out = nib_in;
            end
            default: begin
                nib_out = nib_in;
            end
        endcase
    end

endmodule

// File: rtl/sru_shift_unit.sv
module sru_shift_unit
    import sru_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [2:0]          op,
    input  logic                wide,
    input  logic [WIDE_W-1:0]   operand,
    input  logic [CCR_W-1:0]    ccr_in,
    output logic [WIDE_W-1:0]   result,
    output logic [CCR_W-1:0]    ccr_out
);

    localparam int LANES = 2;

    sru_op_e              op_e;
    logic                 use_wide;
    logic [WIDE_W-1:0]    lane_res [LANES];
    logic [NIB_W-1:0]     lane_nib [LANES];

    assign op_e     = sru_op_e'(op);
    assign use_wide = wide && op_allows_wide(op_e);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
        logic [LW-1:0] core_res;
        logic          core_cout;

        sru_shift_core #(.W(LW)) u_core (
            .op   (op_e),
            .src  (operand[LW-1:0]),
            .cin  (ccr_in[FLAG_C]),
            .res  (core_res),
            .cout (core_cout)
        );

        sru_flag_gen #(.W(LW)) u_flags (
            .op      (op_e),
            .res     (core_res),
            .cout    (core_cout),
            .nib_in  (ccr_in[NIB_W-1:0]),
            .nib_out (lane_nib[g])
        );

        if (LW < WIDE_W) begin : g_ext
            assign lane_res[g] = {{(WIDE_W-LW){1'b0}}, core_res};
        end else begin : g_full
            assign lane_res[g] = core_res;
        end
    end

    always_comb begin
        if (use_wide) begin
            result  = lane_res[1];
            ccr_out = {ccr_in[CCR_W-1:NIB_W], lane_nib[1]};
        end else begin
            result  = lane_res[0];
            ccr_out = {ccr_in[CCR_W-1:NIB_W], lane_nib[0]};
        end
    end

endmodule

// File: rtl/sru_shift_unit_chk.sv
module sru_shift_unit_chk
    import sru_pkg::*;
#(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16
) (
    input  logic [2:0]          op,
    input  logic                wide,
    input  logic [WIDE_W-1:0]   operand,
    input  logic [CCR_W-1:0]    ccr_in,
    input  logic [WIDE_W-1:0]   result,
    input  logic [CCR_W-1:0]    ccr_out
);

    logic known;
    logic narrow;

    assign known  = !$isunknown({op, wide, operand, ccr_in});
    assign narrow = !(wide && op_allows_wide(sru_op_e'(op)));

    always_comb begin
        if (known) begin
            a_r9_upper_ccr_kept: assert (ccr_out[7:4] == ccr_in[7:4])
                else $error("upper condition nibble altered");
            if (op_is_shift(sru_op_e'(op))) begin
                a_r6_v_is_n_xor_c: assert (ccr_out[FLAG_V] == (ccr_out[FLAG_N] ^ ccr_out[FLAG_C]))
                    else $error("V differs from N xor C");
            end
            if (sru_op_e'(op) == OP_COM) begin
                a_r7_com_c_set_v_clr: assert (ccr_out[FLAG_C] && !ccr_out[FLAG_V])
                    else $error("complement flags wrong");
            end
            if (sru_op_e'(op) == OP_CLR) begin
                a_r8_clr_zero_flags: assert (result == '0 && ccr_out[3:0] == 4'b0100)
                    else $error("clear output wrong");
            end
            if (sru_op_e'(op) == OP_NOP) begin
                a_r10_nop_ccr_same: assert (ccr_out == ccr_in)
                    else $error("no-op changed condition register");
            end
            if (narrow) begin
                a_r11_narrow_upper_zero: assert (result[WIDE_W-1:NARROW_W] == '0)
                    else $error("narrow result has upper bits set");
            end
        end
    end

endmodule

bind sru_shift_unit sru_shift_unit_chk #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_chk (
    .op      (op),
    .wide    (wide),
    .operand (operand),
    .ccr_in  (ccr_in),
    .result  (result),
    .ccr_out (ccr_out)
);

// File: tb/sim_sru_shift_unit.sv
module sim_sru_shift_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = 3'd7;
    logic        wide = 1'b0;
    logic [15:0] operand = 16'h0;
    logic [7:0]  ccr_in = 8'h0;
    logic [15:0] result;
    logic [7:0]  ccr_out;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sru_shift_unit u0 (
        .op      (op),
        .wide    (wide),
        .operand (operand),
        .ccr_in  (ccr_in),
        .result  (result),
        .ccr_out (ccr_out)
    );

    // Behavioural reference: integers and bit arithmetic, written from the requirements.
    task automatic model(input int o, input bit w, input int a, input int cc,
                         output int r, output int co, output string tag);
        int width, mask, top, c, n, z, v, x;
        bit wide_ok;
        wide_ok = (o == 0) || (o == 1) || (o == 6) || (o == 7);
        width   = (w && wide_ok) ? 16 : 8;
        mask    = (1 << width) - 1;
        top     = 1 << (width - 1);
        x       = a & mask;
        c       = cc & 1;
        co      = cc;
        case (o)
            0: begin r = x >> 1;                     c = x & 1;          tag = "R1"; end
            1: begin r = (x << 1) & mask;            c = (x & top) ? 1:0; tag = "R2"; end
            2: begin r = (x >> 1) | (x & 'h80);      c = x & 1;          tag = "R3"; end
            3: begin r = (x >> 1) | (c << 7);        c = x & 1;          tag = "R4"; end
            4: begin r = ((x << 1) & 'hff) | c;      c = (x >> 7) & 1;   tag = "R5"; end
            5: begin r = (~x) & 'hff;                c = 1;              tag = "R7"; end
            6: begin r = 0;                          c = 0;              tag = "R8"; end
            default: begin r = x;                                        tag = "R10"; end
        endcase
        n = (r & top) ? 1 : 0;
        z = (r == 0) ? 1 : 0;
        if (o <= 4) begin
            v  = n ^ c;
            co = (cc & 'hf0) | (n << 3) | (z << 2) | (v << 1) | c;
        end else if (o == 5) begin
            co = (cc & 'hf0) | (n << 3) | (z << 2) | 1;
        end else if (o == 6) begin
            co = (cc & 'hf0) | 4;
        end
        if (width == 8 && !w) tag = {tag, "/R11"};
        if (width == 8 && w) tag = {tag, "/R11-narrow"};
    endtask

    task automatic apply(input int o, input bit w, input int a, input int cc);
        int er, ec;
        string tag;
        @(posedge clk);
        op      <= 3'(o);
        wide    <= w;
        operand <= 16'(a);
        ccr_in  <= 8'(cc);
        @(negedge clk);
        model(o, w, a, cc, er, ec, tag);
        n_vec++;
        if (result !== 16'(er)) begin
            n_fail++;
            $display("FAIL %s result op=%0d wide=%0d opd=%h ccr=%h: actual %h expected %h",
                     tag, o, w, a, cc, result, 16'(er));
        end else if (ccr_out !== 8'(ec)) begin
            n_fail++;
            $display("FAIL %s/R6/R9 ccr op=%0d wide=%0d opd=%h ccr=%h: actual %h expected %h",
                     tag, o, w, a, cc, ccr_out, 8'(ec));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-state check: no-op on zero inputs (R10)
        apply(7, 0, 'h0000, 'h00);
        // R1: 8-bit and 16-bit LSR, bit 0 into C, result becoming zero
        apply(0, 0, 'h0001, 'h00);
        apply(0, 1, 'h8001, 'hf0);
        apply(0, 1, 'h0001, 'h0f);
        // R2: LSL carry from bit 7 vs bit 15
        apply(1, 0, 'h0080, 'h00);
        apply(1, 1, 'h0080, 'h00);
        apply(1, 1, 'h8000, 'ha5);
        apply(1, 0, 'h0040, 'h00);
        // R3: ASR keeps sign, wide select ignored (R11)
        apply(2, 0, 'h0081, 'h00);
        apply(2, 1, 'hff81, 'h00);
        // R4/R5: rotates through carry, both carry-in values
        apply(3, 0, 'h0001, 'h01);
        apply(3, 0, 'h0002, 'h00);
        apply(4, 0, 'h0080, 'h00);
        apply(4, 0, 'h0000, 'h01);
        // R7: complement of 0x00 and 0xff
        apply(5, 0, 'h0000, 'h02);
        apply(5, 1, 'h12ff, 'h00);
        // R8: clear preserves upper nibble
        apply(6, 0, 'h00aa, 'hff);
        apply(6, 1, 'hffff, 'h5b);
        // R10/R11: no-op in both widths, upper byte ignored when narrow
        apply(7, 1, 'hbeef, 'h3c);
        apply(7, 0, 'hbeef, 'h3c);
        // pseudo-random sweep over all ops
        for (int i = 0; i < 2000; i++) begin
            apply(int'($urandom_range(0, 7)), 1'($urandom), int'($urandom & 'hffff),
                  int'($urandom & 'hff));
        end
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule